// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block turns the base and limit fields of a bridge's configuration header into two address decode windows, one for I/O space and one for memory space. Software writes new field values and pulses a per-window update strobe. The block then works out whether the programmed range is usable. For a usable range it records the window's bus-side start, its last byte, its size and its CPU-side start. A range whose limit lies below its base removes the window instead.

I/O windows have 4 KB granularity and can span the full 32-bit I/O space through the upper-16 extension fields. The CPU side of an I/O window is moved by a fixed aperture start that comes in on a static input. Memory windows have 1 MB granularity and are not remapped. For every cycle, the block also gives a registered hit flag for one incoming I/O address and one incoming memory address, each checked against the window that is active at that moment. An external address-map fabric can consume the descriptors and their valid flags directly.

Top module: `brwin_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, both windows become invalid after that edge, with every descriptor field at zero, and both hit flags drop to 0.
- R2: A valid I/O window has bus base = {`io_base_hi`, `io_base_lo`[7:4], 12'h000} and last byte = {`io_limit_hi`, `io_limit_lo`[7:4], 12'hFFF}. Its size is last byte minus base.
- R3: The I/O window is invalid when `io_limit_lo` < `io_base_lo` (8-bit unsigned) or when `io_limit_hi` < `io_base_hi`. An update with such values removes the window, and bus base, CPU base and size all read zero.
- R4: A valid I/O window's CPU base equals `io_aperture` plus its bus base, modulo 2^32.
- R5: A valid memory window has base = `mem_base`[15:4] followed by 20 zero bits, and last byte = `mem_limit`[15:4] followed by 20 one bits. Its size is last byte minus base. Its CPU base equals its bus base.
- R6: The memory window is invalid when `mem_limit` < `mem_base` (16-bit unsigned). An update with such values removes it, and its base and size read zero.
- R7: A window's descriptor changes only at a clock edge where its own strobe is high. The new value is visible from the following cycle, and the old one stays on the outputs until then. Field changes without a strobe have no effect.
- R8: `io_hit` is registered. It is 1 in the cycle after `io_addr` is presented exactly when the I/O window active in the presenting cycle is valid and bus base ≤ `io_addr` ≤ bus base + size.
- R9: `mem_hit` is registered. It follows the same rule for `mem_addr` against the memory window.
- R10: A window that is invalid in the presenting cycle gives a hit flag of 0 in the next cycle.
- R11: Bits [3:0] of the I/O and memory base and limit fields affect only the validity comparison, never the base or the size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_upd | input | 1 | Strobe: recompute the I/O window |
| io_base_lo | input | 8 | I/O base field |
| io_limit_lo | input | 8 | I/O limit field |
| io_base_hi | input | 16 | Upper-16 I/O base field |
| io_limit_hi | input | 16 | Upper-16 I/O limit field |
| mem_upd | input | 1 | Strobe: recompute the memory window |
| mem_base | input | 16 | Memory base field |
| mem_limit | input | 16 | Memory limit field |
| io_aperture | input | 32 | Static CPU-side start of the I/O aperture |
| io_addr | input | 32 | I/O bus address to check |
| mem_addr | input | 32 | Memory address to check |
| io_win_valid | output | 1 | I/O window present |
| io_win_bus_base | output | 32 | I/O window bus-side start |
| io_win_cpu_base | output | 32 | I/O window CPU-side start |
| io_win_size | output | 32 | I/O window last byte minus start |
| mem_win_valid | output | 1 | Memory window present |
| mem_win_base | output | 32 | Memory window start |
| mem_win_size | output | 32 | Memory window last byte minus start |
| io_hit | output | 1 | Registered I/O address hit |
| mem_hit | output | 1 | Registered memory address hit |

## Verification
The assertions run on every cycle. They check that the valid flag after each strobe matches the limit-versus-base comparison, and that removed windows read zero and never hit. They also check the granularity fill in the low size bits, the aperture offset on the I/O CPU base, and that descriptors do not move without a strobe. Only the bench scenarios can show the exact base and size values for chosen field patterns, and the inclusive edges of each hit range. They also cover the case where an address arrives in the same cycle as a strobe and is still judged against the old window.

// File: rtl/brwin_pkg.sv
package brwin_pkg;
  localparam int IO_LO_W    = 8;
  localparam int IO_HI_W    = 16;
  localparam int MEM_FLD_W  = 16;
  localparam int NIB_W      = 4;
  localparam int IO_GRAN    = 12;
  localparam int MEM_GRAN   = 20;
  localparam int ADDR_W     = IO_HI_W + (IO_LO_W - NIB_W) + IO_GRAN;
  localparam int NWIN       = 2;
  localparam int WIN_IO     = 0;
  localparam int WIN_MEM    = 1;

  typedef struct packed {
    logic              valid;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] last;
    logic [ADDR_W-1:0] size;
    logic [ADDR_W-1:0] xlat;
  } win_t;
endpackage

// File: rtl/brwin_io_calc.sv
module brwin_io_calc
  import brwin_pkg::*;
#(
  parameter int LO_W = IO_LO_W,
  parameter int HI_W = IO_HI_W,
  parameter int GRAN = IO_GRAN,
  parameter int AW   = ADDR_W
) (
  input  logic [LO_W-1:0] base_lo,
  input  logic [LO_W-1:0] limit_lo,
  input  logic [HI_W-1:0] base_hi,
  input  logic [HI_W-1:0] limit_hi,
  input  logic [AW-1:0]   aperture,
  output win_t            nxt
);
  localparam int TOP_W = LO_W - NIB_W;

  logic          bad;
  logic [AW-1:0] start_a;
  logic [AW-1:0] last_a;

  always_comb begin
    bad     = (limit_lo < base_lo) || (limit_hi < base_hi);
    start_a = {base_hi,  base_lo[LO_W-1 -: TOP_W],  {GRAN{1'b0}}};
    last_a  = {limit_hi, limit_lo[LO_W-1 -: TOP_W], {GRAN{1'b1}}};
    nxt     = '0;
    if (!bad) begin
      nxt.valid = 1'b1;
      nxt.base  = start_a;
      nxt.last  = last_a;
      nxt.size  = last_a - start_a;
      nxt.xlat  = aperture + start_a;
    end
  end
endmodule

// File: rtl/brwin_mem_calc.sv
module brwin_mem_calc
  import brwin_pkg::*;
#(
  parameter int FLD_W = MEM_FLD_W,
  parameter int GRAN  = MEM_GRAN,
  parameter int AW    = ADDR_W
) (
  input  logic [FLD_W-1:0] base_f,
  input  logic [FLD_W-1:0] limit_f,
  output win_t             nxt
);
  localparam int TOP_W = FLD_W - NIB_W;

  logic          bad;
  logic [AW-1:0] start_a;
  logic [AW-1:0] last_a;

  always_comb begin
    bad     = limit_f < base_f;
    start_a = {base_f[FLD_W-1 -: TOP_W],  {GRAN{1'b0}}};
    last_a  = {limit_f[FLD_W-1 -: TOP_W], {GRAN{1'b1}}};
    nxt     = '0;
    if (!bad) begin
      nxt.valid = 1'b1;
      nxt.base  = start_a;
      nxt.last  = last_a;
      nxt.size  = last_a - start_a;
      nxt.xlat  = start_a;
    end
  end
endmodule

// File: rtl/brwin_slot.sv
module brwin_slot
  import brwin_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  win_t          nxt,
  input  logic [AW-1:0] addr,
  output win_t          cur,
  output logic          hit
);
  logic in_range;

  always_comb begin
    in_range = cur.valid && (addr >= cur.base) && (addr <= cur.last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
      hit <= 1'b0;
    end else begin
      if (upd) begin
        cur <= nxt;
      end
      hit <= in_range;
    end
  end
endmodule

// File: rtl/brwin_decoder.sv
module brwin_decoder
  import brwin_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 io_upd,
  input  logic [IO_LO_W-1:0]   io_base_lo,
  input  logic [IO_LO_W-1:0]   io_limit_lo,
  input  logic [IO_HI_W-1:0]   io_base_hi,
  input  logic [IO_HI_W-1:0]   io_limit_hi,
  input  logic                 mem_upd,
  input  logic [MEM_FLD_W-1:0] mem_base,
  input  logic [MEM_FLD_W-1:0] mem_limit,
  input  logic [AW-1:0]        io_aperture,
  input  logic [AW-1:0]        io_addr,
  input  logic [AW-1:0]        mem_addr,
  output logic                 io_win_valid,
  output logic [AW-1:0]        io_win_bus_base,
  output logic [AW-1:0]        io_win_cpu_base,
  output logic [AW-1:0]        io_win_size,
  output logic                 mem_win_valid,
  output logic [AW-1:0]        mem_win_base,
  output logic [AW-1:0]        mem_win_size,
  output logic                 io_hit,
  output logic                 mem_hit
);
  win_t          nxt_w [NWIN];
  win_t          cur_w [NWIN];
  logic          upd_w [NWIN];
  logic [AW-1:0] adr_w [NWIN];
  logic          hit_w [NWIN];

  brwin_io_calc u_io_calc (
    .base_lo  (io_base_lo),
    .limit_lo (io_limit_lo),
    .base_hi  (io_base_hi),
    .limit_hi (io_limit_hi),
    .aperture (io_aperture),
    .nxt      (nxt_w[WIN_IO])
  );

  brwin_mem_calc u_mem_calc (
    .base_f  (mem_base),
    .limit_f (mem_limit),
    .nxt     (nxt_w[WIN_MEM])
  );

  always_comb begin
    upd_w[WIN_IO]  = io_upd;
    upd_w[WIN_MEM] = mem_upd;
    adr_w[WIN_IO]  = io_addr;
    adr_w[WIN_MEM] = mem_addr;
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_slot
    brwin_slot #(.AW(AW)) u_slot (
      .clk  (clk),
      .rst  (rst),
      .upd  (upd_w[g]),
      .nxt  (nxt_w[g]),
      .addr (adr_w[g]),
      .cur  (cur_w[g]),
      .hit  (hit_w[g])
    );
  end

  always_comb begin
    io_win_valid    = cur_w[WIN_IO].valid;
    io_win_bus_base = cur_w[WIN_IO].base;
    io_win_cpu_base = cur_w[WIN_IO].xlat;
    io_win_size     = cur_w[WIN_IO].size;
    mem_win_valid   = cur_w[WIN_MEM].valid;
    mem_win_base    = cur_w[WIN_MEM].base;
    mem_win_size    = cur_w[WIN_MEM].size;
    io_hit          = hit_w[WIN_IO];
    mem_hit         = hit_w[WIN_MEM];
  end
endmodule

// File: rtl/brwin_decoder_chk.sv
module brwin_decoder_chk
  import brwin_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 io_upd,
  input logic [IO_LO_W-1:0]   io_base_lo,
  input logic [IO_LO_W-1:0]   io_limit_lo,
  input logic [IO_HI_W-1:0]   io_base_hi,
  input logic [IO_HI_W-1:0]   io_limit_hi,
  input logic                 mem_upd,
  input logic [MEM_FLD_W-1:0] mem_base,
  input logic [MEM_FLD_W-1:0] mem_limit,
  input logic [ADDR_W-1:0]    io_aperture,
  input logic                 io_win_valid,
  input logic [ADDR_W-1:0]    io_win_bus_base,
  input logic [ADDR_W-1:0]    io_win_cpu_base,
  input logic [ADDR_W-1:0]    io_win_size,
  input logic                 mem_win_valid,
  input logic [ADDR_W-1:0]    mem_win_base,
  input logic [ADDR_W-1:0]    mem_win_size,
  input logic                 io_hit,
  input logic                 mem_hit
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> !io_win_valid && !mem_win_valid && !io_hit && !mem_hit);

  p_io_fill_r2: assert property (@(posedge clk) disable iff (rst)
    io_win_valid |-> (io_win_size[IO_GRAN-1:0] == {IO_GRAN{1'b1}})
                  && (io_win_bus_base[IO_GRAN-1:0] == '0));

  p_io_valid_r3: assert property (@(posedge clk) disable iff (rst)
    io_upd |=> io_win_valid == $past((io_limit_lo >= io_base_lo) &&
                                     (io_limit_hi >= io_base_hi)));

  p_io_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !io_win_valid |-> io_win_bus_base == '0 && io_win_cpu_base == '0 &&
                      io_win_size == '0);

  p_io_cpu_r4: assert property (@(posedge clk) disable iff (rst)
    io_win_valid |-> io_win_cpu_base == io_win_bus_base + io_aperture);

  p_mem_fill_r5: assert property (@(posedge clk) disable iff (rst)
    mem_win_valid |-> (mem_win_size[MEM_GRAN-1:0] == {MEM_GRAN{1'b1}})
                   && (mem_win_base[MEM_GRAN-1:0] == '0));

  p_mem_valid_r6: assert property (@(posedge clk) disable iff (rst)
    mem_upd |=> mem_win_valid == $past(mem_limit >= mem_base));

  p_mem_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !mem_win_valid |-> mem_win_base == '0 && mem_win_size == '0);

  p_io_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !io_upd |=> $stable(io_win_valid) && $stable(io_win_bus_base) &&
                $stable(io_win_size) && $stable(io_win_cpu_base));

  p_mem_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !mem_upd |=> $stable(mem_win_valid) && $stable(mem_win_base) &&
                 $stable(mem_win_size));

  p_io_nohit_r10: assert property (@(posedge clk) disable iff (rst)
    !io_win_valid |=> !io_hit);

  p_mem_nohit_r10: assert property (@(posedge clk) disable iff (rst)
    !mem_win_valid |=> !mem_hit);
endmodule

bind brwin_decoder brwin_decoder_chk u_chk (.*);

// File: tb/brwin_decoder_test.sv
module brwin_decoder_test;
  localparam int NV = 6;
  localparam logic [31:0] APER = 32'hC000_0000;

  localparam logic [7:0]  T_BL [NV] = '{8'h11, 8'h01, 8'h41, 8'h01, 8'h2F, 8'h71};
  localparam logic [7:0]  T_LL [NV] = '{8'h31, 8'hF1, 8'h21, 8'hF1, 8'h20, 8'h71};
  localparam logic [15:0] T_BH [NV] = '{16'h0000, 16'h0001, 16'h0005, 16'h0003, 16'h0000, 16'hABCD};
  localparam logic [15:0] T_LH [NV] = '{16'h0000, 16'h0002, 16'h0005, 16'h0002, 16'h0000, 16'hABCD};
  localparam logic [15:0] T_MB [NV] = '{16'h0010, 16'hE000, 16'h2000, 16'h8000, 16'h100F, 16'h0005};
  localparam logic [15:0] T_ML [NV] = '{16'h00F0, 16'hE0F0, 16'h1FF0, 16'h8000, 16'h1000, 16'h000A};
  localparam logic        E_IV [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [31:0] E_IB [NV] = '{32'h0000_1000, 32'h0001_0000, 32'h0, 32'h0, 32'h0, 32'hABCD_7000};
  localparam logic [31:0] E_IS [NV] = '{32'h0000_2FFF, 32'h0001_FFFF, 32'h0, 32'h0, 32'h0, 32'h0000_0FFF};
  localparam logic        E_MV [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [31:0] E_MB [NV] = '{32'h0010_0000, 32'hE000_0000, 32'h0, 32'h8000_0000, 32'h0, 32'h0};
  localparam logic [31:0] E_MS [NV] = '{32'h00EF_FFFF, 32'h00FF_FFFF, 32'h0, 32'h000F_FFFF, 32'h0, 32'h000F_FFFF};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_upd = 1'b0, mem_upd = 1'b0;
  logic [7:0]  io_base_lo = '0, io_limit_lo = '0;
  logic [15:0] io_base_hi = '0, io_limit_hi = '0, mem_base = '0, mem_limit = '0;
  logic [31:0] io_addr = '0, mem_addr = '0;
  logic        io_win_valid, mem_win_valid, io_hit, mem_hit;
  logic [31:0] io_win_bus_base, io_win_cpu_base, io_win_size, mem_win_base, mem_win_size;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic        m_iv, m_mv;
  logic [31:0] m_ib, m_is, m_mb, m_ms;

  always #5 clk = ~clk;

  brwin_decoder uut (
    .clk(clk), .rst(rst), .io_upd(io_upd), .io_base_lo(io_base_lo),
    .io_limit_lo(io_limit_lo), .io_base_hi(io_base_hi), .io_limit_hi(io_limit_hi),
    .mem_upd(mem_upd), .mem_base(mem_base), .mem_limit(mem_limit),
    .io_aperture(APER), .io_addr(io_addr), .mem_addr(mem_addr),
    .io_win_valid(io_win_valid), .io_win_bus_base(io_win_bus_base),
    .io_win_cpu_base(io_win_cpu_base), .io_win_size(io_win_size),
    .mem_win_valid(mem_win_valid), .mem_win_base(mem_win_base),
    .mem_win_size(mem_win_size), .io_hit(io_hit), .mem_hit(mem_hit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic iu, input logic mu, input logic [7:0] bl, input logic [7:0] ll,
                       input logic [15:0] bh, input logic [15:0] lh,
                       input logic [15:0] mb, input logic [15:0] ml);
    @(negedge clk);
    io_base_lo = bl; io_limit_lo = ll; io_base_hi = bh; io_limit_hi = lh;
    mem_base = mb; mem_limit = ml; io_upd = iu; mem_upd = mu;
    @(negedge clk);
    io_upd = 1'b0; mem_upd = 1'b0;
  endtask

  task automatic check_win(input string tag);
    chk({tag, " R3 io valid"}, {31'b0, io_win_valid}, {31'b0, m_iv});
    chk({tag, " R2 io base"}, io_win_bus_base, m_ib);
    chk({tag, " R2 io size"}, io_win_size, m_is);
    chk({tag, " R4 io cpu base"}, io_win_cpu_base, m_iv ? APER + m_ib : 32'h0);
    chk({tag, " R6 mem valid"}, {31'b0, mem_win_valid}, {31'b0, m_mv});
    chk({tag, " R5 mem base"}, mem_win_base, m_mb);
    chk({tag, " R5 mem size"}, mem_win_size, m_ms);
  endtask

  task automatic probe(input string tag, input logic [31:0] ia, input logic [31:0] ma);
    logic ei, em;
    ei = m_iv && (ia >= m_ib) && ({1'b0, ia} <= {1'b0, m_ib} + {1'b0, m_is});
    em = m_mv && (ma >= m_mb) && ({1'b0, ma} <= {1'b0, m_mb} + {1'b0, m_ms});
    @(negedge clk);
    io_addr = ia; mem_addr = ma;
    @(negedge clk);
    chk({tag, " R8 R10 io hit"}, {31'b0, io_hit}, {31'b0, ei});
    chk({tag, " R9 R10 mem hit"}, {31'b0, mem_hit}, {31'b0, em});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_iv = 0; m_ib = 0; m_is = 0; m_mv = 0; m_mb = 0; m_ms = 0;
    check_win("reset R1");
    chk("reset R1 io hit", {31'b0, io_hit}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      apply(1'b1, 1'b1, T_BL[v], T_LL[v], T_BH[v], T_LH[v], T_MB[v], T_ML[v]);
      m_iv = E_IV[v]; m_ib = E_IB[v]; m_is = E_IS[v];
      m_mv = E_MV[v]; m_mb = E_MB[v]; m_ms = E_MS[v];
      check_win($sformatf("vec%0d", v));
      probe("lower edge", m_ib, m_mb);
      probe("upper edge", m_ib + m_is, m_mb + m_ms);
      probe("above", m_ib + m_is + 32'd1, m_mb + m_ms + 32'd1);
      if (m_ib != 0 || m_mb != 0) probe("below", m_ib - 32'd1, m_mb - 32'd1);
      probe("zero addr R10", 32'h0, 32'h0);
    end

    // R7: field changes without a strobe have no effect
    @(negedge clk);
    io_base_lo = 8'h11; io_limit_lo = 8'h31; io_base_hi = 0; io_limit_hi = 0;
    mem_base = 16'h0010; mem_limit = 16'h00F0;
    repeat (2) @(negedge clk);
    check_win("no strobe R7");

    // R11: low nibbles shift neither base nor size
    apply(1'b1, 1'b1, 8'h70, 8'h7F, 16'hABCD, 16'hABCD, 16'h000F, 16'h000F);
    check_win("low nibble R11");

    // R7/R8: old window stays until the edge; address in strobe cycle uses old window
    apply(1'b1, 1'b0, 8'h11, 8'h31, 16'h0, 16'h0, 16'h0, 16'h0);
    m_iv = 1; m_ib = 32'h0000_1000; m_is = 32'h0000_2FFF;
    check_win("io only R7");
    @(negedge clk);
    io_base_lo = 8'h01; io_limit_lo = 8'hF1; io_base_hi = 16'h1; io_limit_hi = 16'h2;
    io_upd = 1'b1; io_addr = 32'h0000_2000;
    #1 chk("pre-edge old R7", io_win_bus_base, 32'h0000_1000);
    @(negedge clk);
    io_upd = 1'b0;
    chk("strobe-cycle hit R8", {31'b0, io_hit}, 32'h1);
    chk("new base R7", io_win_bus_base, 32'h0001_0000);
    @(negedge clk);
    chk("new window miss R8", {31'b0, io_hit}, 32'h0);

    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1; io_addr = 32'h0001_0000;
    @(negedge clk);
    rst = 1'b0;
    m_iv = 0; m_ib = 0; m_is = 0; m_mv = 0; m_mb = 0; m_ms = 0;
    check_win("mid reset R1");
    chk("mid reset R1 io hit", {31'b0, io_hit}, 32'h0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule